// File: doc/BRIEF.md
# Superslice Dispatch Slot Allocator

The allocator sits between instruction decode and the slice issue queues. Each cycle it receives a group of up to eight decoded ops. Each op carries a rule code and a count of its primary sources. The allocator decides, in the same cycle, which execution slice or branch port each op is steered to.

There are four execution slices, grouped as two superslices. Superslice k holds even slice 2k and odd slice 2k+1. Each slice has a dedicated port. Each superslice has one flexible port that can feed either of its slices. The branch slice has two ports of its own.

Ops are placed strictly in program order. The first op that finds no legal home is stalled, and so are all younger ops in the group. Decode is expected to present the stalled ops again. The allocator also keeps one credit counter per execution slice that tracks free issue-queue entries. A slice with no credit receives nothing.

Top module: `ss_dispatch_alloc`

## Requirements
- R1: After a synchronous active-low reset, every slice credit reads 11. With no valid op, no grant and no stall are raised.
- R2: Ops are considered in program order, op 0 first. The first valid op that cannot be placed is stalled, along with every younger valid op. Ops with `op_vld` low are neither granted nor stalled.
- R3: No more than six ops are granted in one cycle. Ops beyond the sixth grant are stalled.
- R4: Placement of a normal op (rule code 0, also used for codes 6 and 7):
  - It takes the free dedicated port of the lowest-numbered slice that has credit and is not locked; `gnt_tgt` is the slice number, 0 to 3.
  - Failing that, it may use a flexible port, but only when its source count is 2 or less. The lower superslice is tried first, and its even slice is preferred when that slice has credit. `gnt_flex` is then set.
- R5: A vector op (code 1) uses one port of a superslice: the even dedicated port, else the odd dedicated port, else the flexible port if it has at most two sources. It needs credit in both slices and takes one credit from each. It reports the even slice, with `gnt_vec` set.
- R6: An even-only op (code 2) needs both dedicated ports of a superslice free and credit in the even slice. It occupies both ports, reports the even slice, and takes only the even slice's credit.
- R7: A paired op (code 3) dispatches together with the next op, which must also be valid and paired. The first goes to the even slice and the second to the odd slice of one superslice, using both dedicated ports. If this is impossible, neither op is granted.
- R8: A tuple-restricted op (code 4) is placed only on a superslice that no earlier op in the group has touched. It goes to the even slice if that slice has credit, otherwise to the odd slice. The superslice is then closed to all younger ops that cycle.
- R9: A branch op (code 5) takes branch port 0 (`gnt_tgt` 4), then branch port 1 (`gnt_tgt` 5). It uses no slice credit. A third branch op in one group stalls.
- R10: Each slice credit drops by the number of ops sent to it in a cycle, a vector counting for both slices. It rises by that slice's `rel_cnt`, and is clamped at 11. A slice at zero credit is skipped by placement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_vld | input | 8 | Valid bit per op, bit 0 is the oldest |
| op_rule | input | 8x3 | Rule code per op |
| op_nsrc | input | 8x2 | Primary source count per op |
| rel_cnt | input | 4x2 | Issue-queue entries released per slice this cycle |
| gnt | output | 8 | Op placed this cycle |
| gnt_tgt | output | 8x3 | Target per op: slice 0-3, branch port 4-5 |
| gnt_vec | output | 8 | Op delivered to both slices of a superslice |
| gnt_flex | output | 8 | Op sent through a flexible port |
| stall | output | 8 | Valid op held back this cycle |
| credit | output | 4x4 | Free issue-queue entries per slice |

## Verification
The hardest state to reach from the ports is a single slice whose credit is exhausted while its neighbours still have room. Only in that state do the zero-credit skip and the vector op's both-slice credit rule become visible. The bench drains slice 0 alone by sending eleven consecutive even-only ops, which take only the even credit. It then shows even-only, normal and vector ops moving elsewhere. Releases follow, including one that would overfill a slice, together with a release and a dispatch to the same slice in the same cycle.

Table vectors each start from reset. Their mixed groups bring out the ordering interactions: a tuple-restricted op after a touched superslice, pairs followed by vectors that fall back to a flexible port, and the six-grant cap.

// File: rtl/ss_disp_pkg.sv
// Shared definitions for the superslice dispatch allocator.
// Assumes rule codes arrive already decoded on a 3-bit field.
package ss_disp_pkg;

    localparam int RULE_W = 3;

    typedef enum logic [RULE_W-1:0] {
        RULE_NORM  = 3'd0,
        RULE_VEC   = 3'd1,
        RULE_EVEN  = 3'd2,
        RULE_PAIR  = 3'd3,
        RULE_TUPLE = 3'd4,
        RULE_BR    = 3'd5
    } rule_e;

endpackage

// File: rtl/ss_credit.sv
// Issue-queue credit counter for one execution slice.
// Decrements by ops dispatched this cycle, increments by entries released,
// clamps at the queue depth. Assumes dispatch never exceeds current credit.
module ss_credit #(
    parameter int DEPTH = 11,
    parameter int CR_W  = 4,
    parameter int REL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CR_W-1:0]  take,
    input  logic [REL_W-1:0] rel,
    output logic [CR_W-1:0]  credit
);

    int nxt;

    // Next credit value before clamping.
    always_comb nxt = int'(credit) - int'(take) + int'(rel);

    // Credit register with reset to full depth and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            credit <= CR_W'(DEPTH);
        else if (nxt > DEPTH)
            credit <= CR_W'(DEPTH);
        else if (nxt < 0)
            credit <= '0;
        else
            credit <= CR_W'(nxt);
    end

endmodule

// File: rtl/ss_place.sv
// Combinational in-order placement of one dispatch group.
// Walks ops oldest first, tracking port occupancy, superslice locks and
// per-slice credit use within the cycle. Stops at the first op that fails.
// Assumes op_vld bits may have holes; invalid ops are skipped.
module ss_place
    import ss_disp_pkg::*;
#(
    parameter int N_OPS    = 8,
    parameter int N_SS     = 2,
    parameter int N_BR     = 2,
    parameter int MAX_DISP = 6,
    parameter int SRC_LIM  = 2,
    parameter int SRC_W    = 2,
    parameter int CR_W     = 4,
    parameter int TGT_W    = 3
) (
    input  logic [N_OPS-1:0]                  op_vld,
    input  logic [N_OPS-1:0][RULE_W-1:0]      op_rule,
    input  logic [N_OPS-1:0][SRC_W-1:0]       op_nsrc,
    input  logic [2*N_SS-1:0][CR_W-1:0]       credit,
    output logic [N_OPS-1:0]                  gnt,
    output logic [N_OPS-1:0][TGT_W-1:0]       tgt,
    output logic [N_OPS-1:0]                  vec,
    output logic [N_OPS-1:0]                  flex,
    output logic [2*N_SS-1:0][CR_W-1:0]       take
);

    localparam int N_SL = 2 * N_SS;

    logic [N_OPS-1:0] pair_nxt;

    // Flag whether the next op is a valid pairing partner.
    for (genvar g = 0; g < N_OPS; g++) begin : g_pair
        if (g < N_OPS - 1) begin : g_mid
            assign pair_nxt[g] = op_vld[g+1] && (op_rule[g+1] == RULE_PAIR);
        end else begin : g_last
            assign pair_nxt[g] = 1'b0;
        end
    end

    // Sequential walk over the group in program order.
    always_comb begin
        logic [N_SL-1:0] ded_busy;
        logic [N_SS-1:0] fx_busy;
        logic [N_SS-1:0] lock;
        logic [N_SS-1:0] touch;
        logic [N_BR-1:0] br_busy;
        int              used [N_SL];
        int              cnt;
        int              nx;
        logic            halt;
        logic            skip;
        logic            done;
        logic            src_ok;

        ded_busy = '0;
        fx_busy  = '0;
        lock     = '0;
        touch    = '0;
        br_busy  = '0;
        for (int s = 0; s < N_SL; s++) used[s] = 0;
        cnt    = 0;
        nx     = 0;
        halt   = 1'b0;
        skip   = 1'b0;
        done   = 1'b0;
        src_ok = 1'b0;
        gnt    = '0;
        tgt    = '0;
        vec    = '0;
        flex   = '0;

        for (int i = 0; i < N_OPS; i++) begin
            nx     = (i < N_OPS - 1) ? i + 1 : i;
            src_ok = int'(op_nsrc[i]) <= SRC_LIM;
            if (skip) begin
                skip = 1'b0;
            end else if (op_vld[i] && !halt) begin
                done = 1'b0;
                if (cnt < MAX_DISP) begin
                    case (op_rule[i])
                        RULE_VEC: begin
                            for (int k = 0; k < N_SS; k++) begin
                                if (!done && !lock[k] &&
                                    used[2*k]   < int'(credit[2*k]) &&
                                    used[2*k+1] < int'(credit[2*k+1])) begin
                                    if (!ded_busy[2*k]) begin
                                        ded_busy[2*k] = 1'b1;
                                        done = 1'b1;
                                    end else if (!ded_busy[2*k+1]) begin
                                        ded_busy[2*k+1] = 1'b1;
                                        done = 1'b1;
                                    end else if (!fx_busy[k] && src_ok) begin
                                        fx_busy[k] = 1'b1;
                                        flex[i]    = 1'b1;
                                        done = 1'b1;
                                    end
                                    if (done) begin
                                        used[2*k]   = used[2*k] + 1;
                                        used[2*k+1] = used[2*k+1] + 1;
                                        touch[k]    = 1'b1;
                                        vec[i]      = 1'b1;
                                        tgt[i]      = TGT_W'(2*k);
                                    end
                                end
                            end
                        end
                        RULE_EVEN: begin
                            for (int k = 0; k < N_SS; k++) begin
                                if (!done && !lock[k] && !ded_busy[2*k] &&
                                    !ded_busy[2*k+1] &&
                                    used[2*k] < int'(credit[2*k])) begin
                                    ded_busy[2*k]   = 1'b1;
                                    ded_busy[2*k+1] = 1'b1;
                                    used[2*k]       = used[2*k] + 1;
                                    touch[k]        = 1'b1;
                                    tgt[i]          = TGT_W'(2*k);
                                    done            = 1'b1;
                                end
                            end
                        end
                        RULE_PAIR: begin
                            if (pair_nxt[i] && (cnt + 2 <= MAX_DISP)) begin
                                for (int k = 0; k < N_SS; k++) begin
                                    if (!done && !lock[k] && !ded_busy[2*k] &&
                                        !ded_busy[2*k+1] &&
                                        used[2*k]   < int'(credit[2*k]) &&
                                        used[2*k+1] < int'(credit[2*k+1])) begin
                                        ded_busy[2*k]   = 1'b1;
                                        ded_busy[2*k+1] = 1'b1;
                                        used[2*k]       = used[2*k] + 1;
                                        used[2*k+1]     = used[2*k+1] + 1;
                                        touch[k]        = 1'b1;
                                        tgt[i]          = TGT_W'(2*k);
                                        tgt[nx]         = TGT_W'(2*k+1);
                                        gnt[nx]         = 1'b1;
                                        cnt             = cnt + 1;
                                        skip            = 1'b1;
                                        done            = 1'b1;
                                    end
                                end
                            end
                        end
                        RULE_TUPLE: begin
                            for (int k = 0; k < N_SS; k++) begin
                                if (!done && !lock[k] && !touch[k]) begin
                                    if (used[2*k] < int'(credit[2*k])) begin
                                        used[2*k] = used[2*k] + 1;
                                        tgt[i]    = TGT_W'(2*k);
                                        done      = 1'b1;
                                    end else if (used[2*k+1] < int'(credit[2*k+1])) begin
                                        used[2*k+1] = used[2*k+1] + 1;
                                        tgt[i]      = TGT_W'(2*k+1);
                                        done        = 1'b1;
                                    end
                                    if (done) begin
                                        lock[k]  = 1'b1;
                                        touch[k] = 1'b1;
                                    end
                                end
                            end
                        end
                        RULE_BR: begin
                            for (int b = 0; b < N_BR; b++) begin
                                if (!done && !br_busy[b]) begin
                                    br_busy[b] = 1'b1;
                                    tgt[i]     = TGT_W'(N_SL + b);
                                    done       = 1'b1;
                                end
                            end
                        end
                        default: begin
                            for (int s = 0; s < N_SL; s++) begin
                                if (!done && !ded_busy[s] && !lock[s/2] &&
                                    used[s] < int'(credit[s])) begin
                                    ded_busy[s] = 1'b1;
                                    used[s]     = used[s] + 1;
                                    touch[s/2]  = 1'b1;
                                    tgt[i]      = TGT_W'(s);
                                    done        = 1'b1;
                                end
                            end
                            if (!done && src_ok) begin
                                for (int k = 0; k < N_SS; k++) begin
                                    if (!done && !fx_busy[k] && !lock[k]) begin
                                        if (used[2*k] < int'(credit[2*k])) begin
                                            used[2*k] = used[2*k] + 1;
                                            tgt[i]    = TGT_W'(2*k);
                                            done      = 1'b1;
                                        end else if (used[2*k+1] < int'(credit[2*k+1])) begin
                                            used[2*k+1] = used[2*k+1] + 1;
                                            tgt[i]      = TGT_W'(2*k+1);
                                            done        = 1'b1;
                                        end
                                        if (done) begin
                                            fx_busy[k] = 1'b1;
                                            touch[k]   = 1'b1;
                                            flex[i]    = 1'b1;
                                        end
                                    end
                                end
                            end
                        end
                    endcase
                end
                if (done) begin
                    gnt[i] = 1'b1;
                    cnt    = cnt + 1;
                end else begin
                    halt = 1'b1;
                end
            end
        end

        for (int s = 0; s < N_SL; s++) take[s] = CR_W'(used[s]);
    end

endmodule

// File: rtl/ss_dispatch_alloc.sv
// Superslice dispatch slot allocator top level.
// Places a decoded group onto slice and branch ports in one cycle and keeps
// a per-slice issue-queue credit count. Assumes rel_cnt never releases more
// entries than have been dispatched to that slice.
module ss_dispatch_alloc
    import ss_disp_pkg::*;
#(
    parameter int N_OPS    = 8,
    parameter int N_SS     = 2,
    parameter int N_BR     = 2,
    parameter int MAX_DISP = 6,
    parameter int IQ_DEPTH = 11,
    parameter int SRC_LIM  = 2,
    parameter int SRC_W    = 2,
    parameter int REL_W    = 2
) (
    input  logic                                               clk,
    input  logic                                               rst_n,
    input  logic [N_OPS-1:0]                                   op_vld,
    input  logic [N_OPS-1:0][RULE_W-1:0]                       op_rule,
    input  logic [N_OPS-1:0][SRC_W-1:0]                        op_nsrc,
    input  logic [2*N_SS-1:0][REL_W-1:0]                       rel_cnt,
    output logic [N_OPS-1:0]                                   gnt,
    output logic [N_OPS-1:0][$clog2(2*N_SS+N_BR)-1:0]          gnt_tgt,
    output logic [N_OPS-1:0]                                   gnt_vec,
    output logic [N_OPS-1:0]                                   gnt_flex,
    output logic [N_OPS-1:0]                                   stall,
    output logic [2*N_SS-1:0][$clog2(IQ_DEPTH+1)-1:0]          credit
);

    localparam int N_SL  = 2 * N_SS;
    localparam int CR_W  = $clog2(IQ_DEPTH + 1);
    localparam int TGT_W = $clog2(N_SL + N_BR);

    logic [N_SL-1:0][CR_W-1:0] take;

    ss_place #(
        .N_OPS    (N_OPS),
        .N_SS     (N_SS),
        .N_BR     (N_BR),
        .MAX_DISP (MAX_DISP),
        .SRC_LIM  (SRC_LIM),
        .SRC_W    (SRC_W),
        .CR_W     (CR_W),
        .TGT_W    (TGT_W)
    ) u_place (
        .op_vld  (op_vld),
        .op_rule (op_rule),
        .op_nsrc (op_nsrc),
        .credit  (credit),
        .gnt     (gnt),
        .tgt     (gnt_tgt),
        .vec     (gnt_vec),
        .flex    (gnt_flex),
        .take    (take)
    );

    // One credit counter per execution slice.
    for (genvar s = 0; s < N_SL; s++) begin : g_cr
        ss_credit #(
            .DEPTH (IQ_DEPTH),
            .CR_W  (CR_W),
            .REL_W (REL_W)
        ) u_cr (
            .clk    (clk),
            .rst_n  (rst_n),
            .take   (take[s]),
            .rel    (rel_cnt[s]),
            .credit (credit[s])
        );
    end

    // Valid ops that were not placed are held back.
    assign stall = op_vld & ~gnt;

endmodule

// File: rtl/ss_dispatch_alloc_chk.sv
// Property checker for the dispatch allocator, bound to the top module.
// Observes only top-level ports.
module ss_dispatch_alloc_chk
    import ss_disp_pkg::*;
#(
    parameter int N_OPS    = 8,
    parameter int N_SS     = 2,
    parameter int N_BR     = 2,
    parameter int MAX_DISP = 6,
    parameter int IQ_DEPTH = 11,
    parameter int SRC_LIM  = 2,
    parameter int SRC_W    = 2
) (
    input logic                                      clk,
    input logic                                      rst_n,
    input logic [N_OPS-1:0][RULE_W-1:0]              op_rule,
    input logic [N_OPS-1:0][SRC_W-1:0]               op_nsrc,
    input logic [N_OPS-1:0]                          gnt,
    input logic [N_OPS-1:0][$clog2(2*N_SS+N_BR)-1:0] gnt_tgt,
    input logic [N_OPS-1:0]                          gnt_vec,
    input logic [N_OPS-1:0]                          gnt_flex,
    input logic [N_OPS-1:0]                          stall,
    input logic [2*N_SS-1:0][$clog2(IQ_DEPTH+1)-1:0] credit
);

    localparam int N_SL = 2 * N_SS;

    logic [N_SL-1:0] hit;

    // Which slices receive any op this cycle, from the grant outputs.
    always_comb begin
        hit = '0;
        for (int s = 0; s < N_SL; s++) begin
            for (int i = 0; i < N_OPS; i++) begin
                if (gnt[i] && int'(gnt_tgt[i]) == s) hit[s] = 1'b1;
                if (gnt[i] && gnt_vec[i] && int'(gnt_tgt[i]) < N_SL &&
                    int'(gnt_tgt[i]) / 2 == s / 2) hit[s] = 1'b1;
            end
        end
    end

    p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt) <= MAX_DISP);

    for (genvar i = 0; i < N_OPS; i++) begin : g_op
        p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
            stall[i] |-> ((gnt >> i) == '0));
        p_flex_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[i] && gnt_flex[i]) |-> (int'(op_nsrc[i]) <= SRC_LIM));
        p_vec_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[i] && gnt_vec[i]) |-> (gnt_tgt[i][0] == 1'b0));
        p_branch_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[i] && int'(gnt_tgt[i]) >= N_SL) |-> (op_rule[i] == RULE_BR));
    end

    for (genvar s = 0; s < N_SL; s++) begin : g_sl
        p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            int'(credit[s]) <= IQ_DEPTH);
        p_empty_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (credit[s] == '0) |-> !hit[s]);
    end

endmodule

bind ss_dispatch_alloc ss_dispatch_alloc_chk #(
    .N_OPS    (N_OPS),
    .N_SS     (N_SS),
    .N_BR     (N_BR),
    .MAX_DISP (MAX_DISP),
    .IQ_DEPTH (IQ_DEPTH),
    .SRC_LIM  (SRC_LIM),
    .SRC_W    (SRC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_rule  (op_rule),
    .op_nsrc  (op_nsrc),
    .gnt      (gnt),
    .gnt_tgt  (gnt_tgt),
    .gnt_vec  (gnt_vec),
    .gnt_flex (gnt_flex),
    .stall    (stall),
    .credit   (credit)
);

// File: tb/ss_dispatch_alloc_bench.sv
module ss_dispatch_alloc_bench;
    import ss_disp_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n;
    logic [7:0]       op_vld;
    logic [7:0][2:0]  op_rule;
    logic [7:0][1:0]  op_nsrc;
    logic [3:0][1:0]  rel_cnt;
    logic [7:0]       gnt, gnt_vec, gnt_flex, stall;
    logic [7:0][2:0]  gnt_tgt;
    logic [3:0][3:0]  credit;

    int n_chk = 0;
    int n_bad = 0;

    ss_dispatch_alloc u_ss_dispatch_alloc (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_rule(op_rule),
        .op_nsrc(op_nsrc), .rel_cnt(rel_cnt), .gnt(gnt), .gnt_tgt(gnt_tgt),
        .gnt_vec(gnt_vec), .gnt_flex(gnt_flex), .stall(stall), .credit(credit)
    );

    typedef struct packed {
        logic [7:0]      vld;
        logic [7:0][2:0] rule;
        logic [7:0][1:0] nsrc;
        logic [7:0]      egnt;
        logic [7:0]      estall;
        logic [7:0]      eflex;
        logic [7:0]      evec;
        logic [7:0][2:0] etgt;
    } vec_t;

    localparam logic [7:0][1:0] S2 = {8{2'd2}};
    localparam logic [7:0][1:0] S3 = {8{2'd3}};
    localparam int N_VEC = 10;

    localparam vec_t TBL [N_VEC] = '{
        '{vld: 8'hFF, rule: 24'h0, nsrc: S2, egnt: 8'h3F, estall: 8'hC0, eflex: 8'h30, evec: 8'h00,
          etgt: {3'd0,3'd0,3'd2,3'd0,3'd3,3'd2,3'd1,3'd0}},
        '{vld: 8'hFF, rule: 24'h0, nsrc: S3, egnt: 8'h0F, estall: 8'hF0, eflex: 8'h00, evec: 8'h00,
          etgt: {3'd0,3'd0,3'd0,3'd0,3'd3,3'd2,3'd1,3'd0}},
        '{vld: 8'h0F, rule: {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd2},
          nsrc: {2'd2,2'd2,2'd2,2'd2,2'd3,2'd2,2'd2,2'd2},
          egnt: 8'h07, estall: 8'h08, eflex: 8'h00, evec: 8'h00,
          etgt: {3'd0,3'd0,3'd0,3'd0,3'd0,3'd3,3'd2,3'd0}},
        '{vld: 8'h1F, rule: {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd4,3'd0}, nsrc: S2,
          egnt: 8'h0F, estall: 8'h10, eflex: 8'h08, evec: 8'h00,
          etgt: {3'd0,3'd0,3'd0,3'd0,3'd0,3'd1,3'd2,3'd0}},
        '{vld: 8'h1F, rule: {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd4}, nsrc: S2,
          egnt: 8'h0F, estall: 8'h10, eflex: 8'h08, evec: 8'h00,
          etgt: {3'd0,3'd0,3'd0,3'd0,3'd2,3'd3,3'd2,3'd0}},
        '{vld: 8'h3F, rule: {3'd0,3'd0,3'd5,3'd5,3'd1,3'd1,3'd3,3'd3},
          nsrc: {2'd2,2'd2,2'd2,2'd2,2'd3,2'd2,2'd2,2'd2},
          egnt: 8'h3F, estall: 8'h00, eflex: 8'h04, evec: 8'h0C,
          etgt: {3'd0,3'd0,3'd5,3'd4,3'd2,3'd0,3'd1,3'd0}},
        '{vld: 8'h03, rule: {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd3}, nsrc: S2,
          egnt: 8'h00, estall: 8'h03, eflex: 8'h00, evec: 8'h00, etgt: 24'h0},
        '{vld: 8'h0F, rule: {3'd0,3'd0,3'd0,3'd0,3'd0,3'd5,3'd5,3'd5}, nsrc: S2,
          egnt: 8'h03, estall: 8'h0C, eflex: 8'h00, evec: 8'h00,
          etgt: {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd5,3'd4}},
        '{vld: 8'h07, rule: {3'd0,3'd0,3'd0,3'd0,3'd0,3'd2,3'd2,3'd2}, nsrc: S2,
          egnt: 8'h03, estall: 8'h04, eflex: 8'h00, evec: 8'h00,
          etgt: {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd2,3'd0}},
        '{vld: 8'h05, rule: 24'h0, nsrc: S2,
          egnt: 8'h05, estall: 8'h00, eflex: 8'h00, evec: 8'h00,
          etgt: {3'd0,3'd0,3'd0,3'd0,3'd0,3'd1,3'd0,3'd0}}
    };

    // Requirement each table vector exercises.
    function automatic string vec_req(input int idx);
        case (idx)
            0: return "R3/R4";
            1: return "R4";
            2: return "R6";
            3: return "R8";
            4: return "R8/R4";
            5: return "R5/R7/R9";
            6: return "R7/R2";
            7: return "R9";
            8: return "R6/R2";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [7:0][2:0] one_rule(input logic [2:0] code);
        logic [7:0][2:0] r = '0;
        r[0] = code;
        return r;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] v, input logic [7:0][2:0] r,
                         input logic [7:0][1:0] n, input logic [3:0][1:0] rl);
        @(negedge clk);
        op_vld  = v;
        op_rule = r;
        op_nsrc = n;
        rel_cnt = rl;
        #1;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n   = 1'b0;
        op_vld  = '0;
        op_rule = '0;
        op_nsrc = '0;
        rel_cnt = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : main
        rst_n   = 1'b0;
        op_vld  = '0;
        op_rule = '0;
        op_nsrc = '0;
        rel_cnt = '0;
        do_reset();

        // R1: reset state
        for (int s = 0; s < 4; s++) chk("R1", "credit after reset", int'(credit[s]), 11);
        chk("R1", "idle gnt", int'(gnt), 0);
        chk("R1", "idle stall", int'(stall), 0);

        // Vector table, each from reset
        for (int t = 0; t < N_VEC; t++) begin
            do_reset();
            drive(TBL[t].vld, TBL[t].rule, TBL[t].nsrc, '0);
            chk(vec_req(t), $sformatf("v%0d gnt", t), int'(gnt), int'(TBL[t].egnt));
            chk(vec_req(t), $sformatf("v%0d stall", t), int'(stall), int'(TBL[t].estall));
            chk(vec_req(t), $sformatf("v%0d flex", t), int'(gnt_flex), int'(TBL[t].eflex));
            chk(vec_req(t), $sformatf("v%0d vec", t), int'(gnt_vec), int'(TBL[t].evec));
            for (int j = 0; j < 8; j++)
                if (TBL[t].egnt[j])
                    chk(vec_req(t), $sformatf("v%0d tgt op%0d", t, j),
                        int'(gnt_tgt[j]), int'(TBL[t].etgt[j]));
        end

        // R10 / R6: drain slice 0 with even-only ops
        do_reset();
        for (int c = 0; c < 11; c++) begin
            drive(8'h01, one_rule(3'(RULE_EVEN)), S2, '0);
            chk("R6", "drain even tgt", int'(gnt_tgt[0]), 0);
        end
        drive('0, '0, S2, '0);
        chk("R10", "slice0 drained", int'(credit[0]), 0);
        chk("R6", "odd credit untouched", int'(credit[1]), 11);

        // R10: empty slice skipped by each rule
        drive(8'h01, one_rule(3'(RULE_EVEN)), S2, '0);
        chk("R10", "even-only avoids empty slice", int'(gnt_tgt[0]), 2);
        drive(8'h01, one_rule(3'(RULE_NORM)), S2, '0);
        chk("R10", "normal avoids empty slice", int'(gnt_tgt[0]), 1);
        drive(8'h01, one_rule(3'(RULE_VEC)), S2, '0);
        chk("R10", "vector avoids empty superslice", int'(gnt_tgt[0]), 2);
        chk("R5", "vector flag", int'(gnt_vec[0]), 1);

        // R10: releases, vector counted in both slices, clamp
        drive('0, '0, S2, {2'd3, 2'd0, 2'd0, 2'd3});
        chk("R10", "slice1 after one op", int'(credit[1]), 10);
        chk("R5", "slice2 after even and vector", int'(credit[2]), 9);
        chk("R5", "slice3 after vector", int'(credit[3]), 10);
        drive('0, '0, S2, '0);
        chk("R10", "slice0 after release", int'(credit[0]), 3);
        chk("R10", "slice3 clamped", int'(credit[3]), 11);

        // R10: release and dispatch to the same slice in one cycle
        drive(8'h01, one_rule(3'(RULE_NORM)), S2, {2'd0, 2'd0, 2'd0, 2'd1});
        chk("R4", "normal to lowest slice", int'(gnt_tgt[0]), 0);
        drive('0, '0, S2, '0);
        chk("R10", "net zero change", int'(credit[0]), 3);

        // R1: reset restores credits
        do_reset();
        for (int s = 0; s < 4; s++) chk("R1", "credit after re-reset", int'(credit[s]), 11);

        summary();
        $finish;
    end

endmodule